// File: doc/BRIEF.md
# Shared Address/Data Bus Target Controller

This block is the target side of a 32-bit bus on which address and data share the same wires. On the rising clock edge it watches the active-low cycle-frame, initiator-ready and command/byte-enable inputs. When cycle-frame first goes low with the bus idle, that clock is the address phase. The block latches the doubleword address and the command. If the command is a memory read or a memory write and the address falls inside its power-of-two window, it claims the transaction by pulling device-select low.

It then runs one or more data phases. It inserts a configurable number of wait states before it raises target-ready on each phase. A phase completes only on an edge where initiator-ready and target-ready are both low. Writes go into a small register file under per-byte enables. Reads return the stored word with the output enable raised.

The initiator ends a burst by releasing cycle-frame before the final phase. No length count is used. The doubleword index steps by one after each phase and wraps inside the window.

The physical pads sit outside the block. It provides separate output-enable flags for the address/data lines and for the control lines.

Top module: `mbt_target`

## Requirements
- R1: While `rst` is high, `devsel_n` and `trdy_n` read 1 and `ad_oe` and `ctl_oe` read 0 in the same cycle, even in the middle of a transaction. No data phase is in progress after `rst` falls.
- R2: A transaction is claimed only under three conditions:
  - The address phase is an edge where `frame_n` is sampled 0 with the block idle.
  - `cbe_n` is 4'b0110 (memory read) or 4'b0111 (memory write) in that phase.
  - `ad_in[31:2+WIN_DW_LOG2]` equals the same bits of `ADDR_BASE`.

  When claimed, `devsel_n` is low from the next clock on. The starting doubleword index is `ad_in[1+WIN_DW_LOG2:2]`.
- R3: A transaction that misses the window, or carries any other command (for example 4'b0010 or 4'b0011), is never claimed. Its data phases write nothing. The block claims the next qualifying address phase after the bus has gone idle (`frame_n` and `irdy_n` both 1).
- R4: `trdy_n` falls exactly WAIT_STATES+1 clocks after `devsel_n` falls, and exactly WAIT_STATES+1 clocks after each completed non-final phase. It is high on the clock after every completed phase.
- R5: A data phase completes only on an edge where `irdy_n` and `trdy_n` are both sampled 0. While `trdy_n` is 0 and `irdy_n` is 1, `trdy_n` stays 0 and `ad_out` holds its value.
- R6: On a write phase, byte lane i (`ad_in[8i+7:8i]`) is stored only if `cbe_n[i]` is 0. A phase with `cbe_n` = 4'hF changes nothing.
- R7: On a read, `ad_out` carries the stored word of the current index whenever `trdy_n` is 0, and `ad_oe` is 1. On a write, `ad_oe` stays 0.
- R8: Each completed phase advances the doubleword index by one, modulo 2**WIN_DW_LOG2.
- R9: The phase that completes with `frame_n` sampled 1 is the last one. On the next clock `devsel_n` and `trdy_n` are 1 and `ad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; also masks the outputs at once |
| frame_n | input | 1 | Cycle-frame, active low |
| irdy_n | input | 1 | Initiator-ready, active low |
| ad_in | input | 32 | Address/data lines as seen from the bus |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad_out | output | 32 | Read data toward the address/data pads |
| ad_oe | output | 1 | Drive enable for the address/data pads |
| devsel_n | output | 1 | Device-select, active low |
| trdy_n | output | 1 | Target-ready, active low |
| ctl_oe | output | 1 | Drive enable for the device-select and target-ready pads |

## Verification
The bench builds the block with WAIT_STATES = 2, an eight-doubleword window (WIN_DW_LOG2 = 3) and a base of 0x1000. Two wait states make the three-clock target-ready gap distinguishable from an off-by-one. An eight-word window lets a short burst cross the wrap point and return to index 0. Initiator stalls of several clocks are applied while target-ready is low, so that the held read data and the completion rule are both observed.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } mbt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/mbt_decode.sv
module mbt_decode #(
  parameter int          ADDR_W  = 32,
  parameter int          IDX_W   = 3,
  parameter logic [31:0] BASE    = 32'h0000_1000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmd_n,
  output logic              hit,
  output logic              hit_wr,
  output logic [IDX_W-1:0]  hit_idx
);
  import mbt_pkg::*;
  localparam int TAG_LO = 2 + IDX_W;

  logic tag_ok;
  logic is_rd;
  logic is_wr;

  always_comb begin
    tag_ok  = (addr[ADDR_W-1:TAG_LO] == BASE[ADDR_W-1:TAG_LO]);
    is_rd   = (cmd_n == CMD_MEM_RD);
    is_wr   = (cmd_n == CMD_MEM_WR);
    hit     = tag_ok && (is_rd || is_wr);
    hit_wr  = is_wr;
    hit_idx = addr[TAG_LO-1:2];
  end
endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                we,
  input  logic [DATA_W/8-1:0] be,
  input  logic [IDX_W-1:0]    waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                re,
  input  logic [IDX_W-1:0]    raddr,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < LANES; b++) begin
        if (be[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbt_phase_fsm.sv
module mbt_phase_fsm #(
  parameter int IDX_W       = 3,
  parameter int WAIT_STATES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             hit,
  input  logic             hit_wr,
  input  logic [IDX_W-1:0] hit_idx,
  output logic             devsel_q,
  output logic             trdy_q,
  output logic             ad_oe_q,
  output logic             ctl_oe_q,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wr_stb,
  output logic             rd_stb
);
  import mbt_pkg::*;
  localparam int WC_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
  localparam logic [WC_W-1:0] WC_LOAD = WC_W'(WAIT_STATES);

  mbt_state_e      state;
  logic [WC_W-1:0] wcnt;
  logic            cur_wr;
  logic            done;

  always_comb begin
    done   = (state == ST_DATA) && !trdy_q && !irdy_n;
    wr_stb = done && cur_wr;
    rd_stb = (state == ST_DATA) && trdy_q && (wcnt == '0) && !cur_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      devsel_q <= 1'b1;
      trdy_q   <= 1'b1;
      ad_oe_q  <= 1'b0;
      ctl_oe_q <= 1'b0;
      wcnt     <= '0;
      cur_idx  <= '0;
      cur_wr   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            if (hit) begin
              state    <= ST_DATA;
              devsel_q <= 1'b0;
              ctl_oe_q <= 1'b1;
              ad_oe_q  <= !hit_wr;
              cur_wr   <= hit_wr;
              cur_idx  <= hit_idx;
              wcnt     <= WC_LOAD;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          if (done) begin
            trdy_q <= 1'b1;
            if (frame_n) begin
              state    <= ST_IDLE;
              devsel_q <= 1'b1;
              ad_oe_q  <= 1'b0;
              ctl_oe_q <= 1'b0;
            end else begin
              cur_idx <= cur_idx + 1'b1;
              wcnt    <= WC_LOAD;
            end
          end else if (trdy_q) begin
            if (wcnt == '0) trdy_q <= 1'b0;
            else            wcnt   <= wcnt - 1'b1;
          end
        end
        ST_SKIP: begin
          if (frame_n && irdy_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbt_target.sv
module mbt_target #(
  parameter logic [31:0] ADDR_BASE   = 32'h0000_1000,
  parameter int          WIN_DW_LOG2 = 3,
  parameter int          WAIT_STATES = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        ctl_oe
);
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  logic                   hit, hit_wr;
  logic [WIN_DW_LOG2-1:0] hit_idx, cur_idx;
  logic                   devsel_q, trdy_q, ad_oe_q, ctl_oe_q;
  logic                   wr_stb, rd_stb;
  logic [LANES-1:0]       lane_en;

  assign lane_en = ~cbe_n;

  mbt_decode #(.ADDR_W(DATA_W), .IDX_W(WIN_DW_LOG2), .BASE(ADDR_BASE)) u_dec (
    .addr(ad_in), .cmd_n(cbe_n), .hit(hit), .hit_wr(hit_wr), .hit_idx(hit_idx)
  );

  mbt_phase_fsm #(.IDX_W(WIN_DW_LOG2), .WAIT_STATES(WAIT_STATES)) u_fsm (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
    .hit(hit), .hit_wr(hit_wr), .hit_idx(hit_idx),
    .devsel_q(devsel_q), .trdy_q(trdy_q), .ad_oe_q(ad_oe_q), .ctl_oe_q(ctl_oe_q),
    .cur_idx(cur_idx), .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  mbt_regfile #(.DATA_W(DATA_W), .IDX_W(WIN_DW_LOG2)) u_rf (
    .clk(clk), .we(wr_stb), .be(lane_en), .waddr(cur_idx), .wdata(ad_in),
    .re(rd_stb), .raddr(cur_idx), .rdata(ad_out)
  );

  // reset masks the registered outputs without waiting for an edge
  always_comb begin
    devsel_n = devsel_q | rst;
    trdy_n   = trdy_q   | rst;
    ad_oe    = ad_oe_q  & ~rst;
    ctl_oe   = ctl_oe_q & ~rst;
  end
endmodule

// File: rtl/mbt_checker.sv
module mbt_checker (
  input logic        clk,
  input logic        rst,
  input logic        frame_n,
  input logic        irdy_n,
  input logic [3:0]  cbe_n,
  input logic [31:0] ad_out,
  input logic        ad_oe,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        ctl_oe
);
  always @(posedge clk) begin
    if (rst) begin
      assert_reset_quiet_R1: assert (devsel_n && trdy_n && !ad_oe && !ctl_oe)
        else $error("outputs active during reset");
    end
  end

  assert_claim_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n) |-> $past(!frame_n && (cbe_n == 4'b0110 || cbe_n == 4'b0111)));

  assert_gap_after_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && !trdy_n && !irdy_n) |=> trdy_n);

  assert_trdy_needs_devsel_R5: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n);

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out)));

  assert_oe_when_claimed_R7: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !devsel_n);

  assert_release_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    (!devsel_n && !trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe));
endmodule

bind mbt_target mbt_checker u_chk (
  .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
  .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .ctl_oe(ctl_oe)
);

// File: tb/tb_mbt_target.sv
module tb_mbt_target;
  localparam int          WS   = 2;
  localparam int          IW   = 3;
  localparam int          NW   = 1 << IW;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [3:0]  C_RD = 4'b0110;
  localparam logic [3:0]  C_WR = 4'b0111;
  localparam logic [3:0]  C_IOW = 4'b0011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, ctl_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [NW];

  always #5 clk = ~clk;

  mbt_target #(.ADDR_BASE(BASE), .WIN_DW_LOG2(IW), .WAIT_STATES(WS)) dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
    .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .ctl_oe(ctl_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [31:0] a, input logic [3:0] cmd);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = cmd;
    @(posedge clk); @(negedge clk);
  endtask

  // one data phase; entered and left at a falling edge
  task automatic data_phase(input bit wr, input logic [31:0] d, input logic [3:0] be_n,
                            input bit last, input int lag, output logic [31:0] rd,
                            output int hi, output bit oe);
    int   l = lag;
    bit   seen = 1'b0;
    logic [31:0] held = '0;
    hi = 0;
    ad_in = wr ? d : 32'h0; cbe_n = be_n; irdy_n = 1'b1; frame_n = 1'b0;
    forever begin
      if (trdy_n) begin
        hi++;
        if (hi > 40) break;
      end else begin
        if (!seen) begin held = ad_out; seen = 1'b1; end
        else chk(ad_out == held, "R5 data held during stall", ad_out, held);
        if (l == 0) break;
        l--;
      end
      @(posedge clk); @(negedge clk);
    end
    rd = ad_out; oe = ad_oe;
    irdy_n = 1'b0; frame_n = last;
    @(posedge clk); @(negedge clk);
    irdy_n = 1'b1;
  endtask

  task automatic burst(input bit wr, input int start, input int n, input int lag,
                       input logic [3:0] be_n, input logic [31:0] seed);
    logic [31:0] rd, d;
    int hi, idx;
    bit oe;
    addr_phase(BASE + 32'(start * 4), wr ? C_WR : C_RD);
    chk(devsel_n == 1'b0, "R2 claim one clock after address phase", {31'b0, devsel_n}, 32'd0);
    for (int i = 0; i < n; i++) begin
      idx = (start + i) % NW;  // R8 wrap inside window
      d   = seed ^ (32'h0101_0101 * 32'(i + 1));
      data_phase(wr, d, be_n, i == n - 1, lag, rd, hi, oe);
      chk(hi == WS + 1, "R4 wait-state count", 32'(hi), 32'(WS + 1));
      chk(oe == !wr, "R7 ad_oe direction", {31'b0, oe}, {31'b0, !wr});
      if (wr) begin
        for (int b = 0; b < 4; b++)
          if (!be_n[b]) model[idx][8*b +: 8] = d[8*b +: 8];  // R6
      end else begin
        chk(rd == model[idx], "R8/R7 read data at index", rd, model[idx]);
      end
    end
    chk(devsel_n && trdy_n && !ad_oe, "R9 release after final phase",
        {29'b0, devsel_n, trdy_n, ad_oe}, 32'b110);
    frame_n = 1'b1; cbe_n = 4'hF;
  endtask

  task automatic t_reset;
    rst = 1'b1; frame_n = 1'b0; irdy_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && !ad_oe && !ctl_oe, "R1 outputs idle in reset",
        {28'b0, devsel_n, trdy_n, ad_oe, ctl_oe}, 32'b1100);
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk); rst = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset_mid;
    addr_phase(BASE + 32'd8, C_WR);
    chk(ctl_oe == 1'b1, "R2 control drive enabled on claim", {31'b0, ctl_oe}, 32'd1);
    ad_in = 32'hDEAD_BEEF; cbe_n = 4'h0; irdy_n = 1'b0;
    rst = 1'b1; #1;
    chk(devsel_n && trdy_n && !ad_oe && !ctl_oe, "R1 outputs idle at once in reset",
        {28'b0, devsel_n, trdy_n, ad_oe, ctl_oe}, 32'b1100);
    repeat (4) @(negedge clk);
    rst = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
    chk(devsel_n == 1'b1, "R1 no phase pending after reset", {31'b0, devsel_n}, 32'd1);
  endtask

  task automatic t_miss(input logic [31:0] a, input logic [3:0] cmd, input string tag);
    bit claimed = 1'b0;
    addr_phase(a, cmd);
    ad_in = 32'hFFFF_FFFF; cbe_n = 4'h0; irdy_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      frame_n = (i == 3);
      if (!devsel_n || !trdy_n) claimed = 1'b1;
      @(posedge clk); @(negedge clk);
    end
    chk(!claimed && devsel_n, tag, {31'b0, claimed}, 32'd0);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog R4 timeout actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    t_reset();                                  // R1
    burst(1'b1, 0, NW, 0, 4'h0, 32'hA5A5_0000); // R2 R4 R6 R8 R9 fill window
    burst(1'b0, 0, NW, 0, 4'h0, 32'h0);         // R7 readback
    burst(1'b0, 3, NW, 2, 4'h0, 32'h0);         // R5 stalls, R8 wrap
    burst(1'b1, 6, 4, 1, 4'h0, 32'h1234_5678);  // R8 wrap on write
    burst(1'b0, 5, 5, 0, 4'h0, 32'h0);
    burst(1'b1, 2, 1, 0, 4'b1010, 32'h5A5A_C3C3); // R6 bytes 0 and 2 only
    burst(1'b1, 4, 1, 0, 4'hF, 32'h7777_7777);    // R6 no lanes enabled
    burst(1'b0, 2, 3, 3, 4'h0, 32'h0);
    t_miss(BASE + 32'h40, C_WR, "R3 address outside window not claimed");
    t_miss(BASE + 32'h4, C_IOW, "R3 non-memory command not claimed");
    burst(1'b0, 0, NW, 0, 4'h0, 32'h0);         // R3 nothing written by misses
    t_reset_mid();                              // R1
    burst(1'b0, 1, 3, 1, 4'h0, 32'h0);          // R1 reset wrote nothing
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule